// File: doc/BRIEF.md
# Smart Card Power Sequencer

This block orders the power-up and power-down of a smart card slot. Each channel watches its enable input. When enable rises, the channel turns on the card supply. It waits for the regulator to report a good supply, then opens the I/O and reset paths. It opens the clock path on the second rising edge of the card clock after that. When enable falls, the channel closes the reset path at once. It closes the clock path after two card-clock rising edges, or when a timeout expires if the clock has stopped. It closes the I/O path when that timeout expires, and it removes the supply one cycle after the I/O path closes.

The block runs on a fast system clock. The card clock is an asynchronous input that is synchronised once and shared by all channels. Timeouts are counts of system-clock cycles set by parameters. One timeout stands in for the roughly 9 µs power-down delay. A second timeout limits how long a channel waits for supply-good; if it expires, the channel falls back to off, pulses an error flag and stays off until enable is dropped. A ready output marks the fully active state, so that downstream routing can gate on it. Channels are independent instances built by a generate loop.

Top module: `card_pwr_seq`

## Requirements
- R1: During and right after reset every output of every channel is low.
- R2: One cycle after enable is sampled high in the off state, supply enable is high while the reset, I/O and clock gates are all low.
- R3: The I/O and reset gates open one cycle after supply-good is sampled high in the power-up wait, and never before that.
- R4: The clock gate stays closed after the first synchronised card-clock rising edge that follows the I/O gate opening, and it opens on the second such edge.
- R5: One cycle after enable is sampled low, the reset gate is closed.
- R6: During power-down the clock gate closes on the second card-clock rising edge after enable falls, or at the power-down timeout if fewer edges arrive.
- R7: The I/O gate closes OFF_CYC+1 cycles after enable is sampled low, while supply enable is still high; supply enable drops on the following cycle.
- R8: If enable falls while waiting for supply-good, the supply drops two cycles later and no gate opens. If enable falls in the same cycle as the second card-clock edge, the clock gate never opens.
- R9: If supply-good does not arrive within PG_CYC cycles, the channel turns the supply off and raises err for exactly one cycle. It then stays off, with enable still high, until enable is taken low and raised again.
- R10: ready is high only while supply, reset, I/O and clock gates are all open.
- R11: A channel whose enable is low keeps all its outputs low while another channel runs its sequences.
- R12: If enable rises again during power-down, the power-down completes, the supply is off for one cycle, and then a new power-up starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | NUM_CH | Per-channel enable |
| card_clk_i | input | 1 | Asynchronous card clock, shared by all channels |
| supply_good_i | input | NUM_CH | Per-channel supply-good from the regulator |
| supply_en_o | output | NUM_CH | Regulator enable |
| rst_gate_o | output | NUM_CH | Reset path enable |
| io_gate_o | output | NUM_CH | I/O path enable |
| clk_gate_o | output | NUM_CH | Clock path enable |
| ready_o | output | NUM_CH | Channel fully active |
| err_o | output | NUM_CH | One-cycle pulse on supply-good timeout |

## Verification
A falling enable and the second synchronised card-clock edge can reach the state machine in the same cycle. When that happens, power-down must win and the clock gate must stay shut. The bench provokes this by raising the card clock and then, after the two synchroniser stages, dropping enable, so that both reach the same system-clock edge. It then judges that the clock and reset gates stay closed and that the supply is later removed on schedule. A second collision is also exercised: during power-down, a clock edge count and the timeout can both close the clock gate, and either way the gate must be shut by the time the I/O gate closes.

// File: rtl/card_pwr_seq_pkg.sv
package card_pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_RAMP,
    ST_IO_ON,
    ST_ACTIVE,
    ST_DEACT,
    ST_DRAIN
  } seq_state_e;
endpackage

// File: rtl/card_clk_sync.sv
module card_clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/card_pwr_chan.sv
module card_pwr_chan
  import card_pwr_seq_pkg::*;
#(
  parameter int OFF_CYC   = 1125,
  parameter int PG_CYC    = 187500,
  parameter int CLK_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rise_i,
  input  logic pgood_i,
  output logic supply_en_o,
  output logic rst_gate_o,
  output logic io_gate_o,
  output logic clk_gate_o,
  output logic ready_o,
  output logic err_o
);
  localparam int TMAX = (OFF_CYC > PG_CYC) ? OFF_CYC : PG_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int EW   = $clog2(CLK_EDGES + 1);
  localparam logic [EW-1:0] EDGE_LAST = EW'(CLK_EDGES - 1);

  seq_state_e    state_q, state_d;
  logic [EW-1:0] edge_q;
  logic          clk_q, clk_d;
  logic          err_q, err_d;
  logic          lock_q;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          edge_clr;
  logic          edge_last;

  seq_timer #(.W(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  assign edge_last = rise_i && (edge_q == EDGE_LAST);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    edge_clr = 1'b0;
    unique case (state_q)
      ST_OFF: if (en_i && !lock_q) begin
        state_d  = ST_RAMP;
        tmr_load = 1'b1;
        tmr_val  = TW'(PG_CYC - 1);
      end
      ST_RAMP: begin
        if (!en_i)         state_d = ST_DRAIN;   // no gate opened yet
        else if (pgood_i) begin
          state_d  = ST_IO_ON;
          edge_clr = 1'b1;
        end else if (tmr_done) state_d = ST_OFF;
      end
      ST_IO_ON, ST_ACTIVE: begin
        if (!en_i) begin
          state_d  = ST_DEACT;
          tmr_load = 1'b1;
          tmr_val  = TW'(OFF_CYC - 1);
          edge_clr = 1'b1;
        end else if (state_q == ST_IO_ON && edge_last) state_d = ST_ACTIVE;
      end
      ST_DEACT: if (tmr_done) state_d = ST_DRAIN;
      ST_DRAIN: state_d = ST_OFF;
      default:  state_d = ST_OFF;
    endcase
  end

  // clock gate: held through power-down until edge budget or timeout
  assign clk_d = (state_d == ST_ACTIVE)
               | (state_q == ST_ACTIVE && state_d == ST_DEACT)
               | (state_q == ST_DEACT && clk_q && !(tmr_done || edge_last));

  assign err_d = (state_q == ST_RAMP) && en_i && !pgood_i && tmr_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      edge_q  <= '0;
      clk_q   <= 1'b0;
      err_q   <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      clk_q   <= clk_d;
      err_q   <= err_d;
      if (!en_i)      lock_q <= 1'b0;
      else if (err_d) lock_q <= 1'b1;
      if (edge_clr)   edge_q <= '0;
      else if (rise_i && edge_q != EW'(CLK_EDGES)) edge_q <= edge_q + 1'b1;
    end
  end

  assign supply_en_o = (state_q != ST_OFF);
  assign rst_gate_o  = (state_q == ST_IO_ON) || (state_q == ST_ACTIVE);
  assign io_gate_o   = rst_gate_o || (state_q == ST_DEACT);
  assign clk_gate_o  = clk_q;
  assign ready_o     = (state_q == ST_ACTIVE);
  assign err_o       = err_q;

  // R10
  ready_gates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (supply_en_o && rst_gate_o && io_gate_o && clk_gate_o));
  // R2
  ramp_gates_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(supply_en_o) |-> (!rst_gate_o && !io_gate_o && !clk_gate_o));
  // R3
  io_after_pgood_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_gate_o) |-> $past(pgood_i));
  // R5
  rst_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_i) |=> !rst_gate_o);
  // R7
  io_before_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(io_gate_o) |-> supply_en_o);
  // R9
  err_supply_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !supply_en_o);
endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq #(
  parameter int NUM_CH      = 2,
  parameter int OFF_CYC     = 1125,
  parameter int PG_CYC      = 187500,
  parameter int CLK_EDGES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] en_i,
  input  logic              card_clk_i,
  input  logic [NUM_CH-1:0] supply_good_i,
  output logic [NUM_CH-1:0] supply_en_o,
  output logic [NUM_CH-1:0] rst_gate_o,
  output logic [NUM_CH-1:0] io_gate_o,
  output logic [NUM_CH-1:0] clk_gate_o,
  output logic [NUM_CH-1:0] ready_o,
  output logic [NUM_CH-1:0] err_o
);
  logic cclk_rise;

  card_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (card_clk_i),
    .rise_o (cclk_rise)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    card_pwr_chan #(
      .OFF_CYC   (OFF_CYC),
      .PG_CYC    (PG_CYC),
      .CLK_EDGES (CLK_EDGES)
    ) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (en_i[c]),
      .rise_i      (cclk_rise),
      .pgood_i     (supply_good_i[c]),
      .supply_en_o (supply_en_o[c]),
      .rst_gate_o  (rst_gate_o[c]),
      .io_gate_o   (io_gate_o[c]),
      .clk_gate_o  (clk_gate_o[c]),
      .ready_o     (ready_o[c]),
      .err_o       (err_o[c])
    );
  end
endmodule

// File: tb/card_pwr_seq_tb.sv
module card_pwr_seq_tb;
  localparam int NCH = 2;
  localparam int OFF = 40;
  localparam int PG  = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] en = '0;
  logic cclk = 1'b0;
  logic [NCH-1:0] pgood = '0;
  logic [NCH-1:0] sup, rg, iog, cg, rdy, err;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  card_pwr_seq #(.NUM_CH(NCH), .OFF_CYC(OFF), .PG_CYC(PG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .card_clk_i(cclk),
    .supply_good_i(pgood), .supply_en_o(sup), .rst_gate_o(rg),
    .io_gate_o(iog), .clk_gate_o(cg), .ready_o(rdy), .err_o(err)
  );

  // table: channel, cycles before supply-good, clock running during power-down
  localparam int VCH   [4] = '{0, 1, 0, 1};
  localparam int VWAIT [4] = '{3, 10, 50, 120};
  localparam int VCLK  [4] = '{1, 0, 0, 1};

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cclk_pulse();
    cclk = 1'b1; cyc(6);
    cclk = 1'b0; cyc(6);
  endtask

  task automatic power_up(int ch, int w);
    en[ch] = 1'b1; cyc(1);
    chk("R2", "supply on", sup[ch], 1'b1);
    chk("R2", "gates low", rg[ch] | iog[ch] | cg[ch], 1'b0);
    cyc(w);
    chk("R3", "io before pgood", iog[ch], 1'b0);
    pgood[ch] = 1'b1; cyc(1);
    chk("R3", "io open", iog[ch], 1'b1);
    chk("R3", "rst open", rg[ch], 1'b1);
    cclk_pulse();
    chk("R4", "clk after 1st edge", cg[ch], 1'b0);
    chk("R10", "not ready early", rdy[ch], 1'b0);
    cclk_pulse();
    chk("R4", "clk after 2nd edge", cg[ch], 1'b1);
    chk("R10", "ready", rdy[ch], 1'b1);
  endtask

  task automatic power_down(int ch, bit run_clk);
    int n;
    en[ch] = 1'b0; pgood[ch] = 1'b0; cyc(1); n = 1;
    chk("R5", "rst closed", rg[ch], 1'b0);
    chk("R10", "ready dropped", rdy[ch], 1'b0);
    if (run_clk) begin
      cclk_pulse(); cclk_pulse(); n += 24;
      chk("R6", "clk closed by edges", cg[ch], 1'b0);
    end
    cyc(OFF - n);
    chk("R7", "io held", iog[ch], 1'b1);
    if (!run_clk) chk("R6", "clk held until timeout", cg[ch], 1'b1);
    cyc(1);
    chk("R7", "io closed", iog[ch], 1'b0);
    chk("R6", "clk closed", cg[ch], 1'b0);
    chk("R7", "supply still on", sup[ch], 1'b1);
    cyc(1);
    chk("R7", "supply off", sup[ch], 1'b0);
  endtask

  initial begin
    cyc(3);
    chk("R1", "outputs in reset", |{sup, rg, iog, cg, rdy, err}, 1'b0);
    rst_n = 1'b1; cyc(2);
    chk("R1", "outputs after reset", |{sup, rg, iog, cg, rdy, err}, 1'b0);

    for (int i = 0; i < 4; i++) begin
      power_up(VCH[i], VWAIT[i]);
      chk("R11", "idle channel off", |{sup[1-VCH[i]], iog[1-VCH[i]], cg[1-VCH[i]]}, 1'b0);
      power_down(VCH[i], VCLK[i] != 0);
      chk("R11", "idle channel off", sup[1-VCH[i]], 1'b0);
      cyc(3);
    end

    // R8 abort while waiting for supply-good
    en[0] = 1'b1; cyc(1);
    en[0] = 1'b0; cyc(1);
    chk("R8", "drain supply", sup[0], 1'b1);
    chk("R8", "io never open", iog[0], 1'b0);
    cyc(1);
    chk("R8", "supply off", sup[0], 1'b0);
    cyc(3);

    // R8 enable fall meets 2nd clock edge
    en[1] = 1'b1; cyc(1);
    pgood[1] = 1'b1; cyc(1);
    cclk_pulse();
    cclk = 1'b1; cyc(2);
    en[1] = 1'b0; pgood[1] = 1'b0; cyc(1);
    chk("R8", "clk never open", cg[1], 1'b0);
    chk("R8", "rst closed", rg[1], 1'b0);
    cyc(5); cclk = 1'b0;
    chk("R8", "clk still closed", cg[1], 1'b0);
    cyc(OFF);
    chk("R8", "supply removed", sup[1], 1'b0);
    cyc(3);

    // R9 supply-good timeout
    en[0] = 1'b1; cyc(PG);
    chk("R9", "supply before timeout", sup[0], 1'b1);
    chk("R9", "no err yet", err[0], 1'b0);
    cyc(1);
    chk("R9", "err pulse", err[0], 1'b1);
    chk("R9", "supply off", sup[0], 1'b0);
    cyc(1);
    chk("R9", "err one cycle", err[0], 1'b0);
    cyc(5);
    chk("R9", "stays off", sup[0], 1'b0);
    en[0] = 1'b0; cyc(1);
    en[0] = 1'b1; cyc(2);
    chk("R9", "restart after toggle", sup[0], 1'b1);
    en[0] = 1'b0; cyc(4);

    // R12 re-enable during power-down
    power_up(0, 2);
    en[0] = 1'b0; pgood[0] = 1'b0; cyc(5);
    en[0] = 1'b1; cyc(1);
    chk("R12", "rst stays closed", rg[0], 1'b0);
    chk("R12", "io held", iog[0], 1'b1);
    cyc(OFF - 5);
    chk("R12", "drain", iog[0], 1'b0);
    cyc(1);
    chk("R12", "supply off one cycle", sup[0], 1'b0);
    cyc(1);
    chk("R12", "new power-up", sup[0], 1'b1);
    chk("R12", "gates low on restart", iog[0], 1'b0);
    en[0] = 1'b0; cyc(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule